// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider With Phase Offset

This block builds several derived clocks from one fast tick, where each tick is one timing unit. There are three clock groups: bank 1, bank 2 and a feedback output. Each group has its own divide ratio, chosen by a pair of three-level selects. Bank 1 has two phase groups, each with its own offset. Bank 2 and the feedback output each have one offset. Three-level selects arrive as 2-bit codes: 00 is LOW, 01 is MID and 10 is HIGH.

For each group, a divider makes an undelayed square wave from the tick. A tapped shift line then delays that wave by a whole number of timing units. A frequency-select input sets how many ticks make one undivided output period. That keeps the timing unit at a fixed fraction of the nominal period.

A changed divide ratio or frequency select does not take effect at once. The divider adopts it only where the undelayed wave starts a new period, so no short pulse is produced. Bank 2 has a sparse phase table. A code outside that table keeps the previous offset and sets an error flag that stays high until reset.

Top module: `mpclk_gen`

## Requirements
- R1: While `rst_n` is low, every clock output and `b2_ph_err` are low.
- R2: A divide select nibble uses bits [3:2] as the first level and bits [1:0] as the second. Code 11 reads as HIGH. The index 3*first+second picks a ratio R from the list 1, 2, 3, 4, 5, 6, 8, 10, 12, in that order.
- R3: `fs_sel` 00, 01 and 10 (11 reads as HIGH) give N = 32, 16 and 8 ticks per undivided period. A divided output repeats every R*N ticks.
- R4: The undelayed wave is high for N/2 ticks when R=1, for R*N/2 ticks when R is even, and for floor(R/2)*N ticks when R is odd and greater than 1. It is low for the rest of the period. It is high on the first edge after reset release.
- R5: Count the rising clock edges after reset release from 0. At edge j, an output with offset k timing units equals its group's undelayed wave from edge j-9-k. It is low if that edge is before 0.
- R6: In bank 1, the lower half of `b1_q` follows `b1_ph_a_sel` and the upper half follows `b1_ph_b_sel`. Index 0..8 (as in R2) maps to offsets -4..+4.
- R7: `b2_ph_sel` accepts only 0000, 0001, 0010, 0101, 1000, 1001 and 1010. These map to offsets -8, -7, -6, 0, +6, +7 and +8. All six `b2_q` bits are equal. After reset the offset is 0. A new code is applied from the edge after it is sampled.
- R8: An invalid bank-2 code leaves the offset unchanged and sets `b2_ph_err` at that edge. The flag stays set until reset.
- R9: `fb_ph_sel` 00, 01 and 10 (11 reads as HIGH) give feedback offsets -4, 0 and +4.
- R10: A change of divide select or `fs_sel` is adopted only at the edge where the undelayed wave would start a new period. With phase selects held, no output high or low run is shorter than N/2 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing-unit tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs_sel | input | 2 | Frequency range select (three-level code) |
| b1_div_sel | input | 4 | Bank 1 divide select pair |
| b2_div_sel | input | 4 | Bank 2 divide select pair |
| fb_div_sel | input | 4 | Feedback divide select pair |
| b1_ph_a_sel | input | 4 | Bank 1 lower-half phase select pair |
| b1_ph_b_sel | input | 4 | Bank 1 upper-half phase select pair |
| b2_ph_sel | input | 4 | Bank 2 phase select pair |
| fb_ph_sel | input | 2 | Feedback phase select |
| b1_q | output | B1_WIDTH | Bank 1 clock outputs |
| b2_q | output | B2_WIDTH | Bank 2 clock outputs |
| fb_q | output | 1 | Feedback clock output |
| b2_ph_err | output | 1 | Sticky flag for an invalid bank-2 phase code |

## Verification
Divide and frequency selects act at the next period start of the undelayed wave. An output shows that change 9+k edges later, where k is the output's offset. Feedback and bank-1 phase selects are read at the edge they affect. A bank-2 phase code moves the output from the following edge, and the error flag is due on the edge that samples the code. The bench model keeps a short history of each group's undelayed wave, indexed by edge number. It picks the expected value with the same 9+k rule, and its expectations are compared with the ports on every falling edge.

// File: rtl/mpclk_pkg.sv
package mpclk_pkg;

   localparam int TAP_BITS = 5;
   typedef logic [TAP_BITS-1:0] tap_t;

   // three-level code to 0/1/2; code 11 is read as HIGH
   function automatic logic [1:0] lvl3(input logic [1:0] c);
      return c[1] ? 2'd2 : (c[0] ? 2'd1 : 2'd0);
   endfunction

   function automatic logic [3:0] pair_idx(input logic [3:0] s);
      return 4'(3 * lvl3(s[3:2])) + 4'(lvl3(s[1:0]));
   endfunction

   function automatic logic [3:0] ratio_of(input logic [3:0] s);
      logic [3:0] idx;
      idx = pair_idx(s);
      case (idx)
         4'd6:    return 4'd8;
         4'd7:    return 4'd10;
         4'd8:    return 4'd12;
         default: return idx + 4'd1;
      endcase
   endfunction

   function automatic logic [5:0] base_of(input logic [1:0] fs);
      case (lvl3(fs))
         2'd0:    return 6'd32;
         2'd1:    return 6'd16;
         default: return 6'd8;
      endcase
   endfunction

   // taps are offset + 8 ticks
   function automatic tap_t b1_tap(input logic [3:0] s);
      return tap_t'(pair_idx(s)) + tap_t'(4);
   endfunction

   function automatic tap_t fb_tap(input logic [1:0] c);
      return tap_t'({lvl3(c), 2'b00}) + tap_t'(4);
   endfunction

   function automatic logic b2_valid(input logic [3:0] s);
      logic [3:0] idx;
      if (s[3:2] == 2'b11 || s[1:0] == 2'b11) return 1'b0;
      idx = pair_idx(s);
      return !(idx == 4'd3 || idx == 4'd5);
   endfunction

   function automatic tap_t b2_tap(input logic [3:0] s);
      case (pair_idx(s))
         4'd0:    return tap_t'(0);
         4'd1:    return tap_t'(1);
         4'd2:    return tap_t'(2);
         4'd6:    return tap_t'(14);
         4'd7:    return tap_t'(15);
         4'd8:    return tap_t'(16);
         default: return tap_t'(8);
      endcase
   endfunction

endpackage

// File: rtl/mpclk_ratio_cnt.sv
module mpclk_ratio_cnt
   import mpclk_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] div_sel,
   input  logic [1:0] fs_sel,
   output logic       raw_q
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] hi_q;
   logic             pend_q;
   logic [CNT_W-1:0] ratio_w;
   logic [CNT_W-1:0] base_w;
   logic [CNT_W-1:0] per_new;
   logic [CNT_W-1:0] hi_new;
   logic             wrap;

   assign ratio_w = CNT_W'(ratio_of(div_sel));
   assign base_w  = CNT_W'(base_of(fs_sel));
   assign per_new = ratio_w * base_w;
   assign hi_new  = (ratio_w == CNT_W'(1)) ? (base_w >> 1) : ((ratio_w >> 1) * base_w);
   // new ratio is taken only where a period begins
   assign wrap    = pend_q || (cnt_q == per_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_q  <= CNT_W'(1);
         hi_q   <= '0;
         pend_q <= 1'b1;
         raw_q  <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         per_q  <= per_new;
         hi_q   <= hi_new;
         pend_q <= 1'b0;
         raw_q  <= (hi_new != '0);
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         raw_q  <= ((cnt_q + 1'b1) < hi_q);
      end
   end

endmodule

// File: rtl/mpclk_tap_line.sv
module mpclk_tap_line #(
   parameter int DEPTH = 16,
   parameter int NTAP  = 1,
   parameter int TAP_W = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       din,
   input  logic [NTAP-1:0][TAP_W-1:0] tap,
   output logic [NTAP-1:0]            q
);

   logic [DEPTH:1] sr_q;
   logic [DEPTH:0] line;

   assign line = {sr_q, din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
         q    <= '0;
      end else begin
         sr_q <= line[DEPTH-1:0];
         for (int k = 0; k < NTAP; k++) begin
            q[k] <= (int'(tap[k]) <= DEPTH) ? line[tap[k]] : 1'b0;
         end
      end
   end

endmodule

// File: rtl/mpclk_phase_hold.sv
module mpclk_phase_hold
   import mpclk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] sel,
   output tap_t       tap_q,
   output logic       err_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q <= tap_t'(8);
         err_q <= 1'b0;
      end else if (b2_valid(sel)) begin
         tap_q <= b2_tap(sel);
      end else begin
         err_q <= 1'b1;
      end
   end

endmodule

// File: rtl/mpclk_gen.sv
module mpclk_gen
   import mpclk_pkg::*;
#(
   parameter int B1_WIDTH = 4,
   parameter int B2_WIDTH = 6,
   parameter int CNT_W    = 9,
   parameter int TAP_MAX  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          fs_sel,
   input  logic [3:0]          b1_div_sel,
   input  logic [3:0]          b2_div_sel,
   input  logic [3:0]          fb_div_sel,
   input  logic [3:0]          b1_ph_a_sel,
   input  logic [3:0]          b1_ph_b_sel,
   input  logic [3:0]          b2_ph_sel,
   input  logic [1:0]          fb_ph_sel,
   output logic [B1_WIDTH-1:0] b1_q,
   output logic [B2_WIDTH-1:0] b2_q,
   output logic                fb_q,
   output logic                b2_ph_err
);

   localparam int TAP_W     = $clog2(TAP_MAX + 1);
   localparam int MIN_CNT_W = $clog2(12 * 32 + 1);
   localparam int B1_HALF   = B1_WIDTH / 2;

   if (B1_WIDTH < 2 || (B1_WIDTH % 2) != 0) begin : g_bad_b1
      $error("B1_WIDTH must be even and at least 2");
   end
   if (B2_WIDTH < 1) begin : g_bad_b2
      $error("B2_WIDTH must be at least 1");
   end
   if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
      $error("CNT_W too narrow for the longest period");
   end
   if (TAP_MAX < 16 || TAP_W < TAP_BITS) begin : g_bad_tap
      $error("TAP_MAX must reach 16");
   end

   logic raw_b1, raw_b2, raw_fb;
   logic [1:0] q1;
   logic [0:0] q2, qf;
   tap_t b2_tap_q;
   logic [1:0][TAP_W-1:0] tap1;
   logic [0:0][TAP_W-1:0] tap2, tapf;

   mpclk_ratio_cnt #(.CNT_W(CNT_W)) u_b1_div (
      .clk(clk), .rst_n(rst_n), .div_sel(b1_div_sel), .fs_sel(fs_sel), .raw_q(raw_b1));
   mpclk_ratio_cnt #(.CNT_W(CNT_W)) u_b2_div (
      .clk(clk), .rst_n(rst_n), .div_sel(b2_div_sel), .fs_sel(fs_sel), .raw_q(raw_b2));
   mpclk_ratio_cnt #(.CNT_W(CNT_W)) u_fb_div (
      .clk(clk), .rst_n(rst_n), .div_sel(fb_div_sel), .fs_sel(fs_sel), .raw_q(raw_fb));

   mpclk_phase_hold u_b2_ph (
      .clk(clk), .rst_n(rst_n), .sel(b2_ph_sel), .tap_q(b2_tap_q), .err_q(b2_ph_err));

   assign tap1[0] = TAP_W'(b1_tap(b1_ph_a_sel));
   assign tap1[1] = TAP_W'(b1_tap(b1_ph_b_sel));
   assign tap2[0] = TAP_W'(b2_tap_q);
   assign tapf[0] = TAP_W'(fb_tap(fb_ph_sel));

   mpclk_tap_line #(.DEPTH(TAP_MAX), .NTAP(2), .TAP_W(TAP_W)) u_b1_line (
      .clk(clk), .rst_n(rst_n), .din(raw_b1), .tap(tap1), .q(q1));
   mpclk_tap_line #(.DEPTH(TAP_MAX), .NTAP(1), .TAP_W(TAP_W)) u_b2_line (
      .clk(clk), .rst_n(rst_n), .din(raw_b2), .tap(tap2), .q(q2));
   mpclk_tap_line #(.DEPTH(TAP_MAX), .NTAP(1), .TAP_W(TAP_W)) u_fb_line (
      .clk(clk), .rst_n(rst_n), .din(raw_fb), .tap(tapf), .q(qf));

   for (genvar i = 0; i < B1_WIDTH; i++) begin : g_b1_out
      if (i < B1_HALF) begin : g_lo
         assign b1_q[i] = q1[0];
      end else begin : g_hi
         assign b1_q[i] = q1[1];
      end
   end

   assign b2_q = {B2_WIDTH{q2[0]}};
   assign fb_q = qf[0];

endmodule

// File: rtl/mpclk_gen_chk.sv
module mpclk_gen_chk #(
   parameter int B1_WIDTH = 4,
   parameter int B2_WIDTH = 6,
   parameter int CNT_W    = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic [3:0]          b2_ph_sel,
   input logic [1:0]          fb_ph_sel,
   input logic [B1_WIDTH-1:0] b1_q,
   input logic [B2_WIDTH-1:0] b2_q,
   input logic                fb_q,
   input logic                b2_ph_err,
   input logic [CNT_W-1:0]    fb_cnt,
   input logic [CNT_W-1:0]    fb_per,
   input logic [4:0]          b2_tap
);

   logic b2_ok;
   always_comb begin
      case (b2_ph_sel)
         4'b0000, 4'b0001, 4'b0010, 4'b0101,
         4'b1000, 4'b1001, 4'b1010: b2_ok = 1'b1;
         default:                   b2_ok = 1'b0;
      endcase
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (b1_q == '0 && b2_q == '0 && !fb_q && !b2_ph_err));

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      b2_ph_err |=> b2_ph_err);

   a_r8_bad_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !b2_ok |=> b2_ph_err);

   a_r8_bad_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !b2_ok |=> $stable(b2_tap));

   a_r10_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      fb_cnt < fb_per);

   a_r10_fb_no_runt_hi: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fb_q) && $stable(fb_ph_sel)) |=> (fb_q || $changed(fb_ph_sel)));

   a_r10_fb_no_runt_lo: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fb_q) && $stable(fb_ph_sel)) |=> (!fb_q || $changed(fb_ph_sel)));

endmodule

bind mpclk_gen mpclk_gen_chk #(
   .B1_WIDTH(B1_WIDTH), .B2_WIDTH(B2_WIDTH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .b2_ph_sel(b2_ph_sel), .fb_ph_sel(fb_ph_sel),
   .b1_q(b1_q), .b2_q(b2_q), .fb_q(fb_q), .b2_ph_err(b2_ph_err),
   .fb_cnt(u_fb_div.cnt_q), .fb_per(u_fb_div.per_q), .b2_tap(u_b2_ph.tap_q)
);

// File: tb/mpclk_gen_bench.sv
module mpclk_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int B1W = 4;
   localparam int B2W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic [1:0] fs_sel = 2'b10, fb_ph_sel = 2'b01;
   logic [3:0] b1_div_sel = 4'b0000, b2_div_sel = 4'b0000, fb_div_sel = 4'b0000;
   logic [3:0] b1_ph_a_sel = 4'b0101, b1_ph_b_sel = 4'b0101, b2_ph_sel = 4'b0101;
   logic [B1W-1:0] b1_q;
   logic [B2W-1:0] b2_q;
   logic fb_q, b2_ph_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpclk_gen #(.B1_WIDTH(B1W), .B2_WIDTH(B2W)) u_mpclk_gen (
      .clk(clk), .rst_n(rst_n), .fs_sel(fs_sel), .b1_div_sel(b1_div_sel),
      .b2_div_sel(b2_div_sel), .fb_div_sel(fb_div_sel), .b1_ph_a_sel(b1_ph_a_sel),
      .b1_ph_b_sel(b1_ph_b_sel), .b2_ph_sel(b2_ph_sel), .fb_ph_sel(fb_ph_sel),
      .b1_q(b1_q), .b2_q(b2_q), .fb_q(fb_q), .b2_ph_err(b2_ph_err));

   int n_chk = 0, n_err = 0;
   bit chk_on = 0, done = 0;
   string tag = "R1";

   // ---- requirement tables (independent of the RTL) ----
   function automatic int lv(input logic [1:0] c);
      return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
   endfunction
   function automatic int sidx(input logic [3:0] s);
      return 3 * lv(s[3:2]) + lv(s[1:0]);
   endfunction
   function automatic int ratio(input logic [3:0] s);
      int rt[9] = '{1, 2, 3, 4, 5, 6, 8, 10, 12};
      return rt[sidx(s)];
   endfunction
   function automatic int nbase(input logic [1:0] f);
      int nt[3] = '{32, 16, 8};
      return nt[lv(f)];
   endfunction
   function automatic logic [3:0] code(input int k);
      logic [1:0] lc[3] = '{2'b00, 2'b01, 2'b10};
      return {lc[k/3], lc[k%3]};
   endfunction
   function automatic int b2_off(input logic [3:0] s);  // -99 = invalid
      case (s)
         4'b0000: return -8;
         4'b0001: return -7;
         4'b0010: return -6;
         4'b0101: return 0;
         4'b1000: return 6;
         4'b1001: return 7;
         4'b1010: return 8;
         default: return -99;
      endcase
   endfunction

   // ---- behavioural model ----
   int  mc[3], mp[3], mh[3];
   bit  mfirst;
   bit  hist[3][32];
   int  j;
   int  m_b2off;
   bit  merr;
   logic [B1W-1:0] e_b1;
   logic [B2W-1:0] e_b2;
   logic e_fb, e_err;

   function automatic bit past_wave(input int d, input int dly);
      int idx;
      idx = j - dly;
      return (idx >= 0) ? hist[d][idx % 32] : 1'b0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         j = 0; mfirst = 1; m_b2off = 0; merr = 0;
         e_b1 = '0; e_b2 = '0; e_fb = 0; e_err = 0;
      end else begin
         bit va, vb, v2, vf;
         logic [3:0] sel;
         int r, n, o;
         va = past_wave(0, 9 + sidx(b1_ph_a_sel) - 4);
         vb = past_wave(0, 9 + sidx(b1_ph_b_sel) - 4);
         v2 = past_wave(1, 9 + m_b2off);
         vf = past_wave(2, 9 + 4 * lv(fb_ph_sel) - 4);
         for (int i = 0; i < B1W; i++) e_b1[i] = (i < B1W/2) ? va : vb;
         e_b2 = {B2W{v2}};
         e_fb = vf;
         for (int d = 0; d < 3; d++) begin
            sel = (d == 0) ? b1_div_sel : (d == 1) ? b2_div_sel : fb_div_sel;
            if (mfirst || mc[d] == mp[d] - 1) begin
               r = ratio(sel); n = nbase(fs_sel);
               mc[d] = 0; mp[d] = r * n;
               mh[d] = (r == 1) ? n / 2 : (r / 2) * n;
            end else begin
               mc[d] = mc[d] + 1;
            end
            hist[d][j % 32] = (mc[d] < mh[d]);
         end
         mfirst = 0;
         o = b2_off(b2_ph_sel);
         if (o == -99) merr = 1; else m_b2off = o;
         e_err = merr;
         j = j + 1;
      end
   end

   task automatic cmp(input string what, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s [%s] actual %0h expected %0h at %0t", what, req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on && !done) begin
         cmp("b1_q", {tag, " R5 R6"}, 16'(b1_q), 16'(e_b1));
         cmp("b2_q", {tag, " R5 R7"}, 16'(b2_q), 16'(e_b2));
         cmp("fb_q", {tag, " R5 R9"}, 16'(fb_q), 16'(e_fb));
         cmp("b2_ph_err", {tag, " R8"}, 16'(b2_ph_err), 16'(e_err));
      end
   end

   task automatic do_reset();
      @(negedge clk) rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired [all requirements] actual running expected done");
      finish_run();
   end

   initial begin
      #1 rst_n = 0;
      chk_on = 1;
      // R1: outputs quiet while held in reset
      repeat (4) @(negedge clk);
      // R2 R3 R4: basic ratios, zero offsets, N = 8
      tag = "R2 R3 R4";
      b1_div_sel = 4'b0001; b2_div_sel = 4'b0101; fb_div_sel = 4'b0000;
      rst_n = 1;
      repeat (200) @(negedge clk);
      // R6 R7 R9: phase tables, applied across reset
      tag = "R6 R7 R9";
      for (int k = 0; k < 9; k++) begin
         logic [3:0] b2c[7] = '{4'b0000, 4'b0001, 4'b0010, 4'b0101, 4'b1000, 4'b1001, 4'b1010};
         @(negedge clk);
         b1_ph_a_sel = code(k); b1_ph_b_sel = code(8 - k);
         b2_ph_sel = b2c[k % 7];
         fb_ph_sel = (k % 3 == 0) ? 2'b00 : (k % 3 == 1) ? 2'b01 : 2'b10;
         do_reset();
         repeat (100) @(negedge clk);
      end
      // R10 R2: ratio changes while running
      tag = "R10 R2";
      for (int k = 0; k < 9; k++) begin
         @(negedge clk);
         fb_div_sel = code(k); b1_div_sel = code(8 - k); b2_div_sel = code((k + 4) % 9);
         repeat (150) @(negedge clk);
      end
      // R3 R10: frequency select changes, code 11 read as HIGH
      tag = "R3 R10";
      @(negedge clk) fs_sel = 2'b01;
      repeat (600) @(negedge clk);
      fs_sel = 2'b00;
      repeat (900) @(negedge clk);
      tag = "R2 R3";
      fs_sel = 2'b11; b1_div_sel = 4'b1111; fb_div_sel = 4'b0011;
      repeat (300) @(negedge clk);
      fs_sel = 2'b10;
      // R8: invalid bank-2 codes hold offset, flag is sticky
      tag = "R8";
      b2_ph_sel = 4'b1000;
      repeat (100) @(negedge clk);
      b2_ph_sel = 4'b0100;
      repeat (100) @(negedge clk);
      b2_ph_sel = 4'b0011;
      repeat (50) @(negedge clk);
      b2_ph_sel = 4'b0000;
      repeat (100) @(negedge clk);
      // R1: reset clears the flag
      tag = "R1 R8";
      do_reset();
      repeat (50) @(negedge clk);
      finish_run();
   end

endmodule